// File: doc/BRIEF.md
# Criticality-Guided Dispatch Steering

This block decides, for every instruction leaving dispatch, whether it goes to the fast out-of-order issue path or to the slow in-order path. The decision comes from a learned table of small saturating counters, indexed by the low bits of the instruction address. The table has to supply a guess at dispatch because an instruction's age in the issue queue is not yet known at that point.

The table trains itself at run time from issue-queue age. Each cycle the surrounding pipeline presents the addresses of the N oldest valid issue-queue entries, and optionally the producer of the oldest entry, together with the address of the instruction that issues in that cycle. An issuing instruction found in that snapshot counts as critical and its counter steps up. Otherwise its counter steps down. Predicted-critical work is sent to the fast units. Everything else goes to the in-order units, whose latency is twice as long. When the chosen queue is full the block falls back to the other queue, and it stalls when both are full.

Top module: `crit_steer`

## Requirements
- R1: Reset clears every counter to 0, so after reset any dispatched instruction is predicted non-critical and steered slow (`steer_fast`=0).
- R2: A counter value of 2 or 3 predicts critical, which steers to the fast path (`steer_fast`=1). Values 0 and 1 steer to the slow path.
- R3: An issuing instruction whose full address equals that of any valid entry of the oldest-N snapshot increments its counter, which saturates at 3.
- R4: An issuing instruction that matches neither the snapshot nor the producer input decrements its counter, which saturates at 0.
- R5: With producer training enabled (the default), a valid producer address equal to the issuing address counts as a match in the same way as a snapshot entry.
- R6: The table is direct-mapped. The index is address bits [IDX_W-1:0], so addresses that differ only above those bits share one counter.
- R7: A lookup and a training update to the same index in the same cycle see the counter value from before the update.
- R8: If the preferred queue reports full and the other queue does not, the instruction is steered to the other queue.
- R9: If both queues report full, the cycle produces `steer_stall`=1 and `steer_valid`=0.
- R10: When `steer_valid`=1, `steer_lat` is FAST_LAT for fast steering and 2*FAST_LAT for slow steering.
- R11: Outputs are registered and appear one clock after the dispatch input. In a cycle without dispatch, or during reset, `steer_valid` and `steer_stall` are 0 at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | An instruction is presented for steering |
| disp_pc | input | PC_W | Address of the dispatched instruction |
| ooo_full | input | 1 | Fast out-of-order queue cannot accept |
| ino_full | input | 1 | Slow in-order queue cannot accept |
| old_valid | input | OLD_N | Valid bit for each oldest-N snapshot slot |
| old_pc | input | OLD_N*PC_W | Snapshot addresses, slot k at bits [k*PC_W +: PC_W] |
| prod_valid | input | 1 | Producer-of-oldest address is valid |
| prod_pc | input | PC_W | Producer-of-oldest address |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_pc | input | PC_W | Address of the issuing instruction |
| steer_valid | output | 1 | A steering decision was made |
| steer_fast | output | 1 | 1: fast out-of-order path, 0: slow in-order path |
| steer_stall | output | 1 | Dispatch blocked because both queues are full |
| steer_lat | output | LAT_W | Latency class of the chosen path |

## Verification
Lookup and training are the two functions that can hit the same counter in one clock. The bench forces this by dispatching an address in the same cycle that address issues and trains, both at a counter value of 1. It expects the slow decision from the old value, and then the fast decision on the next dispatch. The random phase draws dispatch, snapshot and issue addresses from a small pool, so that collisions, aliasing and full-queue fallbacks occur often. Each of these cases is judged against a bench-side counter model that is updated only after the expected decision has been taken from it.

// File: rtl/crit_pkg.sv
package crit_pkg;
  typedef logic [1:0] ctr_t;
  typedef enum logic [1:0] {CTR_HOLD = 2'd0, CTR_UP = 2'd1, CTR_DOWN = 2'd2} ctr_op_e;

  localparam ctr_t CTR_MAX    = 2'd3;
  localparam ctr_t CTR_THRESH = 2'd2;

  function automatic ctr_t ctr_next(input ctr_t c, input ctr_op_e op);
    case (op)
      CTR_UP:   return (c == CTR_MAX) ? c : ctr_t'(c + 2'd1);
      CTR_DOWN: return (c == 2'd0) ? c : ctr_t'(c - 2'd1);
      default:  return c;
    endcase
  endfunction
endpackage

// File: rtl/crit_table.sv
module crit_table
  import crit_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  output ctr_t             lk_ctr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  ctr_op_e          upd_op
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (upd_en) begin
      mem[upd_idx] <= ctr_next(mem[upd_idx], upd_op);
    end
  end

  // read before write: lookup sees the value held ahead of this edge (R7)
  assign lk_ctr = mem[lk_idx];

  // R1: the clock after reset leaves every counter at zero
  a_r1_clear: assert property (@(posedge clk) rst |=> lk_ctr == '0);

  // R3: an increment at the top value leaves it there
  a_r3_up_sat: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_op == CTR_UP && mem[upd_idx] == CTR_MAX)
      |=> mem[$past(upd_idx)] == CTR_MAX);

  // R4: a decrement at zero leaves it there
  a_r4_down_floor: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_op == CTR_DOWN && mem[upd_idx] == 2'd0)
      |=> mem[$past(upd_idx)] == 2'd0);
endmodule

// File: rtl/crit_train.sv
module crit_train
  import crit_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int OLD_N   = 4,
  parameter bit PROD_EN = 1'b1
) (
  input  logic [OLD_N-1:0]      old_valid,
  input  logic [OLD_N*PC_W-1:0] old_pc,
  input  logic                  prod_valid,
  input  logic [PC_W-1:0]       prod_pc,
  input  logic                  iss_valid,
  input  logic [PC_W-1:0]       iss_pc,
  output logic                  upd_en,
  output logic [IDX_W-1:0]      upd_idx,
  output ctr_op_e               upd_op
);
  logic [OLD_N-1:0] hit;
  logic             prod_hit;

  for (genvar k = 0; k < OLD_N; k++) begin : g_slot
    assign hit[k] = old_valid[k] && (old_pc[k*PC_W +: PC_W] == iss_pc);
  end

  if (PROD_EN) begin : g_prod
    assign prod_hit = prod_valid && (prod_pc == iss_pc);
  end else begin : g_noprod
    assign prod_hit = 1'b0;
    logic unused_prod;
    assign unused_prod = ^{prod_valid, prod_pc};
  end

  assign upd_en  = iss_valid;
  assign upd_idx = iss_pc[IDX_W-1:0];
  assign upd_op  = (|hit || prod_hit) ? CTR_UP : CTR_DOWN;
endmodule

// File: rtl/crit_steer_sel.sv
module crit_steer_sel #(
  parameter int LAT_W    = 3,
  parameter int FAST_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_valid,
  input  logic             pred_crit,
  input  logic             ooo_full,
  input  logic             ino_full,
  output logic             steer_valid,
  output logic             steer_fast,
  output logic             steer_stall,
  output logic [LAT_W-1:0] steer_lat
);
  logic go_ok, go_fast;

  always_comb begin
    go_ok   = 1'b1;
    go_fast = 1'b0;
    if (pred_crit) begin
      if (!ooo_full)      go_fast = 1'b1;
      else if (ino_full)  go_ok   = 1'b0;
    end else begin
      if (ino_full) begin
        if (!ooo_full) go_fast = 1'b1;
        else           go_ok   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      steer_valid <= 1'b0;
      steer_fast  <= 1'b0;
      steer_stall <= 1'b0;
      steer_lat   <= '0;
    end else begin
      steer_valid <= disp_valid && go_ok;
      steer_stall <= disp_valid && !go_ok;
      steer_fast  <= disp_valid && go_ok && go_fast;
      if (disp_valid && go_ok)
        steer_lat <= go_fast ? LAT_W'(FAST_LAT) : LAT_W'(2 * FAST_LAT);
      else
        steer_lat <= '0;
    end
  end

  // R8: preferred fast queue full, slow one free -> slow
  a_r8_redirect: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && pred_crit && ooo_full && !ino_full) |=> (steer_valid && !steer_fast));

  // R9: both full -> stall and no decision
  a_r9_stall: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && ooo_full && ino_full) |=> (steer_stall && !steer_valid));

  // R11: no dispatch -> nothing next cycle
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !disp_valid |=> (!steer_valid && !steer_stall));

  // R10: slow latency is twice the fast one
  a_r10_lat: assert property (@(posedge clk) disable iff (rst)
    (steer_valid && !steer_fast) |-> (steer_lat == LAT_W'(2 * FAST_LAT)));
endmodule

// File: rtl/crit_steer.sv
module crit_steer
  import crit_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int IDX_W    = 6,
  parameter int OLD_N    = 4,
  parameter bit PROD_EN  = 1'b1,
  parameter int FAST_LAT = 2,
  localparam int LAT_W   = $clog2(2 * FAST_LAT + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  disp_valid,
  input  logic [PC_W-1:0]       disp_pc,
  input  logic                  ooo_full,
  input  logic                  ino_full,
  input  logic [OLD_N-1:0]      old_valid,
  input  logic [OLD_N*PC_W-1:0] old_pc,
  input  logic                  prod_valid,
  input  logic [PC_W-1:0]       prod_pc,
  input  logic                  iss_valid,
  input  logic [PC_W-1:0]       iss_pc,
  output logic                  steer_valid,
  output logic                  steer_fast,
  output logic                  steer_stall,
  output logic [LAT_W-1:0]      steer_lat
);
  logic             upd_en;
  logic [IDX_W-1:0] upd_idx;
  ctr_op_e          upd_op;
  ctr_t             lk_ctr;
  logic             unused_disp_hi;

  assign unused_disp_hi = ^disp_pc[PC_W-1:IDX_W];

  crit_train #(
    .PC_W(PC_W), .IDX_W(IDX_W), .OLD_N(OLD_N), .PROD_EN(PROD_EN)
  ) u_train (
    .old_valid (old_valid),
    .old_pc    (old_pc),
    .prod_valid(prod_valid),
    .prod_pc   (prod_pc),
    .iss_valid (iss_valid),
    .iss_pc    (iss_pc),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_op    (upd_op)
  );

  crit_table #(.IDX_W(IDX_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .lk_idx (disp_pc[IDX_W-1:0]),
    .lk_ctr (lk_ctr),
    .upd_en (upd_en),
    .upd_idx(upd_idx),
    .upd_op (upd_op)
  );

  crit_steer_sel #(.LAT_W(LAT_W), .FAST_LAT(FAST_LAT)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .pred_crit  (lk_ctr >= CTR_THRESH),
    .ooo_full   (ooo_full),
    .ino_full   (ino_full),
    .steer_valid(steer_valid),
    .steer_fast (steer_fast),
    .steer_stall(steer_stall),
    .steer_lat  (steer_lat)
  );
endmodule

// File: tb/test_crit_steer.sv
`timescale 1ns/1ps
module test_crit_steer;
  localparam int PC_W = 32, IDX_W = 6, OLD_N = 4, FAST_LAT = 2;
  localparam int LAT_W = $clog2(2 * FAST_LAT + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic dv = 0, off = 0, inf = 0, pv = 0, iv = 0;
  logic [PC_W-1:0] dpc = '0, ppc = '0, ipc = '0;
  logic [OLD_N-1:0] ov = '0;
  logic [OLD_N*PC_W-1:0] opc = '0;
  logic steer_valid, steer_fast, steer_stall;
  logic [LAT_W-1:0] steer_lat;

  int checks = 0, failures = 0;
  int mdl [1 << IDX_W];

  always #5 clk = ~clk;

  crit_steer #(.PC_W(PC_W), .IDX_W(IDX_W), .OLD_N(OLD_N), .FAST_LAT(FAST_LAT)) i_crit_steer (
    .clk(clk), .rst(rst), .disp_valid(dv), .disp_pc(dpc), .ooo_full(off), .ino_full(inf),
    .old_valid(ov), .old_pc(opc), .prod_valid(pv), .prod_pc(ppc), .iss_valid(iv), .iss_pc(ipc),
    .steer_valid(steer_valid), .steer_fast(steer_fast), .steer_stall(steer_stall), .steer_lat(steer_lat));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_match();
    bit m = (pv && ppc == ipc);
    for (int k = 0; k < OLD_N; k++)
      if (ov[k] && opc[k*PC_W +: PC_W] == ipc) m = 1;
    return m;
  endfunction

  // inputs are set at a negedge; expectations are taken from the model before it trains
  task automatic cyc(input string tag);
    bit want, ev, ef, es;
    int i;
    want = mdl[dpc[IDX_W-1:0]] >= 2;
    ev = 0; ef = 0; es = 0;
    if (dv) begin
      if (want) begin
        if (!off) begin ev = 1; ef = 1; end
        else if (!inf) ev = 1;
        else es = 1;
      end else begin
        if (!inf) ev = 1;
        else if (!off) begin ev = 1; ef = 1; end
        else es = 1;
      end
    end
    if (iv) begin
      i = ipc[IDX_W-1:0];
      if (is_match()) begin if (mdl[i] < 3) mdl[i]++; end
      else if (mdl[i] > 0) mdl[i]--;
    end
    @(negedge clk);
    chk(tag, "steer_valid", steer_valid, ev);
    chk(tag, "steer_stall", steer_stall, es);
    if (ev) begin
      chk(tag, "steer_fast", steer_fast, ef);
      chk("R10", "steer_lat", steer_lat, ef ? FAST_LAT : 2 * FAST_LAT);
    end
  endtask

  task automatic idle();
    dv = 0; off = 0; inf = 0; pv = 0; iv = 0; ov = '0; opc = '0;
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input bit hit, input string tag);
    idle(); iv = 1; ipc = pc; ov[2] = hit; opc[2*PC_W +: PC_W] = pc;
    cyc(tag);
  endtask

  task automatic disp(input logic [PC_W-1:0] pc, input string tag);
    idle(); dv = 1; dpc = pc;
    cyc(tag);
  endtask

  function automatic logic [PC_W-1:0] rpc();
    return PC_W'((($urandom % 4) << IDX_W) | ($urandom % 8));
  endfunction

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << IDX_W); i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset state of the outputs
    chk("R11", "reset steer_valid", steer_valid, 0);
    chk("R11", "reset steer_stall", steer_stall, 0);
    disp(32'h10, "R1");                         // cleared counter -> slow
    train(32'h10, 1, "R3");                     // ctr 1
    idle(); iv = 1; ipc = 32'h10; ov[0] = 1; opc[PC_W-1:0] = 32'h10;
    dv = 1; dpc = 32'h10; cyc("R7");             // sees 1 -> slow, ctr becomes 2
    disp(32'h10, "R2");                         // fast
    for (int n = 0; n < 3; n++) train(32'h10, 1, "R3");  // saturate at 3
    train(32'h10, 0, "R4"); train(32'h10, 0, "R4");      // 1
    disp(32'h10, "R3");                         // slow: proves saturation
    for (int n = 0; n < 3; n++) train(32'h20, 0, "R4");  // floor at 0
    train(32'h20, 1, "R3"); train(32'h20, 1, "R3");      // 2
    disp(32'h20, "R4");                         // fast: proves floor
    for (int n = 0; n < 2; n++) begin
      idle(); iv = 1; ipc = 32'h30; pv = 1; ppc = 32'h30; cyc("R5");
    end
    disp(32'h30, "R5");                         // fast via producer training
    disp(32'h70, "R6");                         // alias of 0x30 -> fast
    idle(); dv = 1; dpc = 32'h30; off = 1; cyc("R8");    // fast wanted, redirected slow
    idle(); dv = 1; dpc = 32'h40; inf = 1; cyc("R8");    // slow wanted, redirected fast
    idle(); dv = 1; dpc = 32'h30; off = 1; inf = 1; cyc("R9");
    idle(); cyc("R11");
    for (int n = 0; n < 3000; n++) begin
      dv = ($urandom % 4) != 0; dpc = rpc();
      off = ($urandom % 5) == 0; inf = ($urandom % 5) == 0;
      ov = OLD_N'($urandom);
      for (int k = 0; k < OLD_N; k++) opc[k*PC_W +: PC_W] = rpc();
      pv = $urandom % 2; ppc = rpc();
      iv = ($urandom % 4) != 0;
      ipc = ($urandom % 2) ? opc[($urandom % OLD_N)*PC_W +: PC_W] : rpc();
      cyc("R2");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule